// File: doc/BRIEF.md
# Fixed-Latency Multicycle Path Controller

This block drives a combinational path that needs several clock periods to settle and has no registers inside it. Several data waves can travel through such a path at once. Here the path is modelled as an identity function. The block accepts input words through a valid/ready handshake and launches each accepted word into the path. It captures the result a fixed number of cycles later and hands it to the receiver in launch order.

Three parameters describe the path:

- `LAT_S` is the settling latency in cycles.
- `INTV_I` is the minimum spacing between launches.
- `COPIES_M` is the number of parallel copies of the path. Successive waves are tagged to the copies in rotation.

The legal combinations satisfy LAT_S ≥ INTV_I ≥ 1 and LAT_S ≥ COPIES_M ≥ 1. In addition, INTV_I and COPIES_M may not both exceed 1. Any other combination stops elaboration.

The `BUFFERED` parameter selects the output variant. With `BUFFERED` = 0, each result appears on the output for a single cycle and the receiver cannot hold it back. With `BUFFERED` = 1, the receiver may stall the output. A wave that has already been launched cannot be stopped, so every launch reserves a slot in an output queue before it leaves. The input is refused while no slot is free.

Top module: `wp_path_ctrl`

## Requirements
- R1: A word accepted at clock edge k (in_valid and in_ready both high) appears on out_data with out_valid high immediately after edge k+LAT_S+1. In the buffered variant this holds when the queue is empty and out_ready is held high.
- R2: With BUFFERED=0, each result keeps out_valid high for exactly one cycle, and out_ready has no effect on the output.
- R3: After an accepted word, in_ready stays low for INTV_I-1 cycles. With in_valid held high and INTV_I=2, in_ready therefore alternates 1,0,1,0.
- R4: Every output word equals its input word, and words leave in the order they were accepted.
- R5: With COPIES_M>1 and INTV_I=1, the buffered block accepts one word per cycle without a wait while out_ready stays high.
- R6: With BUFFERED=1, out_valid is high while the queue holds a word. While out_ready is low, the head word stays on out_data unchanged.
- R7: With BUFFERED=1 and out_ready held low from an empty state, exactly LAT_S+3 words are accepted, after which in_ready stays low.
- R8: While rst_n is low and after its release, out_valid is 0 and in_ready is 1. Waves in flight at reset never appear at the output.
- R9: After a stall, every accepted word is delivered once out_ready returns high. None is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Source offers a word |
| in_ready | output | 1 | Block can launch a word this cycle |
| in_data | input | DATA_W | Word to launch |
| out_valid | output | 1 | Result available on out_data |
| out_ready | input | 1 | Receiver takes the result (buffered variant only) |
| out_data | output | DATA_W | Captured result |

## Verification
An age counter that is stuck or skips a count shows as a word that arrives early or late, or never arrives. The bench sees this LAT_S+1 cycles after the launch, because it compares each word's arrival edge with its launch edge. A credit counter that drifts shows in two ways. If it drifts low, in_ready stays low early and the number of words accepted during a stall is too small. If it drifts high, queue entries are overwritten, and the next drain delivers wrong or missing words. A broken interval counter changes the in_ready pattern within one or two cycles of the first accepted word.

// File: rtl/wp_pkg.sv
package wp_pkg;

  // Legal timing constant combinations for the wrapped path.
  function automatic bit wp_params_legal(input int lat_s, input int intv_i, input int copies_m);
    return (intv_i >= 1) && (lat_s >= intv_i) &&
           (copies_m >= 1) && (lat_s >= copies_m) &&
           ((intv_i == 1) || (copies_m == 1));
  endfunction

  // Output queue depth: one launch-to-pop lifetime is LAT_S+2 edges,
  // plus one slot so the credit test can use the registered count alone.
  function automatic int wp_queue_depth(input int lat_s);
    return lat_s + 3;
  endfunction

endpackage

// File: rtl/wp_issue_gate.sv
module wp_issue_gate #(
  parameter int LAT_S    = 4,
  parameter int INTV_I   = 1,
  parameter int DEPTH    = 7,
  parameter bit BUFFERED = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic pop,
  output logic in_ready,
  output logic launch
);

  localparam int GAP_W  = (INTV_I > 1) ? $clog2(INTV_I) : 1;
  localparam int FREE_W = $clog2(DEPTH + 1);
  localparam logic [GAP_W-1:0]  GAP_LOAD  = GAP_W'(INTV_I - 1);
  localparam logic [FREE_W-1:0] FREE_INIT = FREE_W'(DEPTH);

  logic [GAP_W-1:0]  gap_q, gap_d;
  logic              gap_en;
  logic [FREE_W-1:0] free_q, free_d;
  logic              free_en;
  logic              credit_ok;

  assign credit_ok = BUFFERED ? (free_q != '0) : 1'b1;
  assign in_ready  = (gap_q == '0) && credit_ok;
  assign launch    = in_valid && in_ready;

  // Interval counter: blocks new launches for INTV_I-1 cycles.
  always_comb begin
    gap_en = launch || (gap_q != '0);
    gap_d  = gap_q;
    if (launch) begin
      gap_d = GAP_LOAD;
    end else if (gap_q != '0) begin
      gap_d = gap_q - 1'b1;
    end
  end

  // Free-slot credits: a launch reserves a queue slot, a pop returns it.
  always_comb begin
    free_en = BUFFERED && (launch != pop);
    free_d  = free_q;
    if (launch && !pop) begin
      free_d = free_q - 1'b1;
    end else if (pop && !launch) begin
      free_d = free_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else if (gap_en) begin
      gap_q <= gap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q <= FREE_INIT;
    end else if (free_en) begin
      free_q <= free_d;
    end
  end

  // Independent spacing monitor for the interval rule.
  logic [GAP_W-1:0] since_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= GAP_LOAD;
    end else if (launch) begin
      since_q <= '0;
    end else if (since_q != GAP_LOAD) begin
      since_q <= since_q + 1'b1;
    end
  end

  AST_ISSUE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (since_q == GAP_LOAD)); // R3

  AST_CREDIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !BUFFERED || (free_q <= FREE_INIT)); // R7

endmodule

// File: rtl/wp_wave_tracker.sv
module wp_wave_tracker #(
  parameter int DATA_W   = 16,
  parameter int LAT_S    = 4,
  parameter int COPIES_M = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [DATA_W-1:0] launch_data,
  output logic              arrive,
  output logic [DATA_W-1:0] arrive_data
);

  localparam int NSLOT = LAT_S + 1;
  localparam int AGE_W = $clog2(LAT_S + 1);
  localparam int PTR_W = $clog2(NSLOT);
  localparam int CP_W  = (COPIES_M > 1) ? $clog2(COPIES_M) : 1;
  localparam logic [AGE_W-1:0] AGE_DONE = AGE_W'(LAT_S);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NSLOT - 1);
  localparam logic [CP_W-1:0]  CP_LAST  = CP_W'(COPIES_M - 1);

  logic [NSLOT-1:0]  vld_q, vld_d, hit, load;
  logic [AGE_W-1:0]  age_q [NSLOT];
  logic [AGE_W-1:0]  age_d [NSLOT];
  logic [DATA_W-1:0] dat_q [NSLOT];
  logic [CP_W-1:0]   tag_q [NSLOT];
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [CP_W-1:0]   cp_q, cp_d;
  logic [CP_W-1:0]   arrive_tag;

  // One slot per wave that can be in flight at one launch per cycle.
  for (genvar j = 0; j < NSLOT; j++) begin : g_slot
    assign hit[j]   = vld_q[j] && (age_q[j] == AGE_DONE);
    assign load[j]  = launch && (ptr_q == PTR_W'(j));
    assign vld_d[j] = load[j] || (vld_q[j] && !hit[j]);
    assign age_d[j] = load[j] ? '0 : (age_q[j] + AGE_W'(vld_q[j] && !hit[j]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[j] <= 1'b0;
        age_q[j] <= '0;
      end else begin
        vld_q[j] <= vld_d[j];
        age_q[j] <= age_d[j];
      end
    end

    always_ff @(posedge clk) begin
      if (load[j]) begin
        dat_q[j] <= launch_data;
        tag_q[j] <= cp_q;
      end
    end
  end

  // Round-robin slot and path-copy selection.
  always_comb begin
    ptr_d = (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
    cp_d  = (cp_q == CP_LAST) ? '0 : cp_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cp_q  <= '0;
    end else if (launch) begin
      ptr_q <= ptr_d;
      cp_q  <= cp_d;
    end
  end

  // Capture mux: at most one wave completes per cycle.
  always_comb begin
    arrive_data = '0;
    arrive_tag  = '0;
    for (int j = 0; j < NSLOT; j++) begin
      if (hit[j]) begin
        arrive_data = arrive_data | dat_q[j];
        arrive_tag  = arrive_tag | tag_q[j];
      end
    end
  end
  assign arrive = |hit;

  // Expected copy at capture time, rotated independently of launch side.
  logic [CP_W-1:0] cap_cp_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_cp_q <= '0;
    end else if (arrive) begin
      cap_cp_q <= (cap_cp_q == CP_LAST) ? '0 : cap_cp_q + 1'b1;
    end
  end

  AST_ONE_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)); // R4

  AST_SLOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (!vld_q[ptr_q] || hit[ptr_q])); // R9

  AST_COPY_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    arrive |-> (arrive_tag == cap_cp_q)); // R5

endmodule

// File: rtl/wp_out_stage.sv
module wp_out_stage #(
  parameter int DATA_W   = 16,
  parameter int DEPTH    = 7,
  parameter bit BUFFERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              pop
);

  if (BUFFERED) begin : g_fifo
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp_q, wp_d, rp_q, rp_d;
    logic [CW-1:0]     cnt_q, cnt_d;

    assign out_valid = (cnt_q != '0);
    assign out_data  = mem[rp_q];
    assign pop       = out_valid && out_ready;

    always_comb begin
      wp_d  = (wp_q == PTR_LAST) ? '0 : wp_q + 1'b1;
      rp_d  = (rp_q == PTR_LAST) ? '0 : rp_q + 1'b1;
      cnt_d = cnt_q;
      if (push && !pop) begin
        cnt_d = cnt_q + 1'b1;
      end else if (pop && !push) begin
        cnt_d = cnt_q - 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp_q  <= '0;
        rp_q  <= '0;
        cnt_q <= '0;
      end else begin
        if (push) wp_q <= wp_d;
        if (pop)  rp_q <= rp_d;
        if (push != pop) cnt_q <= cnt_d;
      end
    end

    always_ff @(posedge clk) begin
      if (push) begin
        mem[wp_q] <= push_data;
      end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (cnt_q < CNT_FULL)); // R9

    AST_HOLD_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6

  end else begin : g_reg
    logic              vld_q;
    logic [DATA_W-1:0] dat_q;
    logic              unused_rdy;

    assign unused_rdy = out_ready;
    assign out_valid  = vld_q;
    assign out_data   = dat_q;
    assign pop        = vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
      end else begin
        vld_q <= push;
      end
    end

    always_ff @(posedge clk) begin
      if (push) begin
        dat_q <= push_data;
      end
    end

    AST_CAPTURE_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> (out_valid && (out_data == $past(push_data)))); // R2

  end

endmodule

// File: rtl/wp_path_ctrl.sv
module wp_path_ctrl #(
  parameter int DATA_W   = 16,
  parameter int LAT_S    = 4,
  parameter int INTV_I   = 1,
  parameter int COPIES_M = 2,
  parameter bit BUFFERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  import wp_pkg::*;

  localparam int DEPTH = wp_queue_depth(LAT_S);

  if (!wp_params_legal(LAT_S, INTV_I, COPIES_M)) begin : g_bad_params
    $error("wp_path_ctrl: illegal LAT_S/INTV_I/COPIES_M combination");
  end

  logic              launch;
  logic              pop;
  logic              arrive;
  logic [DATA_W-1:0] arrive_data;

  wp_issue_gate #(
    .LAT_S   (LAT_S),
    .INTV_I  (INTV_I),
    .DEPTH   (DEPTH),
    .BUFFERED(BUFFERED)
  ) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .pop     (pop),
    .in_ready(in_ready),
    .launch  (launch)
  );

  wp_wave_tracker #(
    .DATA_W  (DATA_W),
    .LAT_S   (LAT_S),
    .COPIES_M(COPIES_M)
  ) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .launch_data(in_data),
    .arrive     (arrive),
    .arrive_data(arrive_data)
  );

  wp_out_stage #(
    .DATA_W  (DATA_W),
    .DEPTH   (DEPTH),
    .BUFFERED(BUFFERED)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (arrive),
    .push_data(arrive_data),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_data (out_data),
    .pop      (pop)
  );

endmodule

// File: tb/wp_path_ctrl_tb.sv
module wp_path_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW   = 16;
  localparam int SA   = 4;   // u_dut: buffered, two copies
  localparam int SB   = 3;   // u_dut_b: unbuffered, interval 2
  localparam int DEPA = SA + 3;

  // Stimulus table: {data, idle cycles after}; expected result is the data itself.
  localparam logic [19:0] VEC [8] = '{
    {16'hA5A5, 4'd0}, {16'h0000, 4'd0}, {16'hFFFF, 4'd0}, {16'h1234, 4'd0},
    {16'h8001, 4'd0}, {16'h7FFE, 4'd2}, {16'h5A5A, 4'd0}, {16'hC3C3, 4'd5}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          a_in_valid = 1'b0, a_in_ready, a_out_valid, a_out_ready = 1'b1;
  logic [DW-1:0] a_in_data = '0, a_out_data;
  logic          b_in_valid = 1'b0, b_in_ready, b_out_valid, b_out_ready = 1'b0;
  logic [DW-1:0] b_in_data = '0, b_out_data;

  wp_path_ctrl #(.DATA_W(DW), .LAT_S(SA), .INTV_I(1), .COPIES_M(2), .BUFFERED(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(a_in_valid), .in_ready(a_in_ready), .in_data(a_in_data),
    .out_valid(a_out_valid), .out_ready(a_out_ready), .out_data(a_out_data));

  wp_path_ctrl #(.DATA_W(DW), .LAT_S(SB), .INTV_I(2), .COPIES_M(1), .BUFFERED(1'b0)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .in_valid(b_in_valid), .in_ready(b_in_ready), .in_data(b_in_data),
    .out_valid(b_out_valid), .out_ready(b_out_ready), .out_data(b_out_data));

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit lat_a = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Scoreboards
  logic [DW-1:0] exp_a [64];
  int            lc_a  [64];
  int            wr_a = 0, rd_a = 0;
  logic [DW-1:0] exp_b [64];
  int            lc_b  [64];
  int            wr_b = 0, rd_b = 0;
  bit            prev_bv = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (a_in_valid && a_in_ready) begin
        exp_a[wr_a % 64] = a_in_data;
        lc_a[wr_a % 64]  = cyc + 1;
        wr_a++;
      end
      if (a_out_valid && a_out_ready) begin
        chk(rd_a < wr_a, "R9 no extra word", rd_a, wr_a);
        chk(a_out_data == exp_a[rd_a % 64], "R4 data/order A", a_out_data, exp_a[rd_a % 64]);
        if (lat_a) chk(cyc == lc_a[rd_a % 64] + SA + 1, "R1 latency A", cyc, lc_a[rd_a % 64] + SA + 1);
        rd_a++;
      end
      if (b_in_valid && b_in_ready) begin
        exp_b[wr_b % 64] = b_in_data;
        lc_b[wr_b % 64]  = cyc + 1;
        wr_b++;
      end
      if (b_out_valid) begin
        chk(!prev_bv, "R2 one-cycle valid", prev_bv, 0);
        chk(b_out_data == exp_b[rd_b % 64], "R4 data/order B", b_out_data, exp_b[rd_b % 64]);
        chk(cyc == lc_b[rd_b % 64] + SB + 1, "R1 latency B (out_ready low, R2)", cyc, lc_b[rd_b % 64] + SB + 1);
        rd_b++;
      end
      prev_bv = b_out_valid;
    end
  end

  task automatic send_a(input logic [DW-1:0] d, output int waits);
    waits = 0;
    a_in_valid = 1'b1;
    a_in_data  = d;
    @(negedge clk);
    while (!a_in_ready) begin
      waits++;
      @(negedge clk);
    end
    @(posedge clk);
    #1;
    a_in_valid = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int w;
    int acc;
    // R8: reset state
    repeat (2) @(negedge clk);
    chk(a_out_valid == 1'b0, "R8 reset out_valid A", a_out_valid, 0);
    chk(a_in_ready == 1'b1, "R8 reset in_ready A", a_in_ready, 1);
    chk(b_out_valid == 1'b0, "R8 reset out_valid B", b_out_valid, 0);
    chk(b_in_ready == 1'b1, "R8 reset in_ready B", b_in_ready, 1);
    step();
    rst_n = 1'b1;
    step();

    // Table walk: R1, R4 checked by the monitor, R5 no wait at one word per cycle
    for (int v = 0; v < 8; v++) begin
      send_a(VEC[v][19:4], w);
      chk(w == 0, "R5 no wait on copies", w, 0);
      repeat (int'(VEC[v][3:0])) step();
    end
    repeat (SA + 6) step();
    chk(rd_a == wr_a && wr_a == 8, "R4 all table words out", rd_a, 8);

    // Stall: R7 credit limit, R6 hold, R9 no loss
    lat_a = 1'b0;
    a_out_ready = 1'b0;
    acc = 0;
    a_in_valid = 1'b1;
    a_in_data  = 16'h3000;
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      if (a_in_ready) acc++;
      @(posedge clk);
      #1;
      a_in_data = 16'h3000 + DW'(acc);
    end
    a_in_valid = 1'b0;
    @(negedge clk);
    chk(acc == DEPA, "R7 words accepted in stall", acc, DEPA);
    chk(a_in_ready == 1'b0, "R7 in_ready low when full", a_in_ready, 0);
    chk(a_out_valid == 1'b1, "R6 valid while queued", a_out_valid, 1);
    chk(a_out_data == 16'h3000, "R6 head word", a_out_data, 16'h3000);
    repeat (3) @(negedge clk);
    chk(a_out_data == 16'h3000 && a_out_valid, "R6 head held stable", a_out_data, 16'h3000);
    step();
    a_out_ready = 1'b1;
    repeat (DEPA + 4) step();
    chk(rd_a == wr_a, "R9 all stalled words delivered", rd_a, wr_a);
    chk(a_out_valid == 1'b0, "R6 valid low when empty", a_out_valid, 0);
    lat_a = 1'b1;

    // Unbuffered, interval 2: R3 ready pattern, R2 via monitor
    b_in_valid = 1'b1;
    b_in_data  = 16'h0B00;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk(b_in_ready == ((k % 2) == 0), "R3 ready spacing", b_in_ready, (k % 2) == 0);
      @(posedge clk);
      #1;
      b_in_data = b_in_data + 16'h0011;
    end
    b_in_valid = 1'b0;
    repeat (SB + 4) step();
    chk(rd_b == wr_b && wr_b == 5, "R4 all unbuffered words out", rd_b, 5);

    // Reset with a wave in flight: R8
    send_a(16'hDEAD, w);
    step();
    rst_n = 1'b0;
    rd_a = wr_a;
    repeat (2) step();
    rst_n = 1'b1;
    @(negedge clk);
    chk(a_in_ready == 1'b1, "R8 ready after reset", a_in_ready, 1);
    for (int k = 0; k < SA + 3; k++) begin
      chk(a_out_valid == 1'b0, "R8 flushed wave absent", a_out_valid, 0);
      @(negedge clk);
    end

    done = 1'b1;
    finish_run();
  end

endmodule